// File: doc/BRIEF.md
# Real-Time Clock Pulse-Swallowing Calibrator

This block trims the rate of a slow real-time-clock tick stream by deleting a programmed number of input pulses in every window of 2^WIN_BITS input pulses (2^20 by default). Each unit of the 7-bit calibration value slows the clock by 10^6 / 2^20 ppm, which is about 0.954 ppm. The full range is 127 steps, or about 121 ppm. A value of zero leaves the stream untouched. The input clock arrives as a one-cycle enable, `tick_in`, on the system clock. The trimmed stream leaves as `tick_out` and feeds a downstream prescaler.

The deleted pulses are spread through the window and do not come as one burst. A tick at window position p is removed when the bit-reversed value of p is less than the active calibration value. In the default 20-bit window this puts every removed pulse on a position that is a multiple of 2^13. Software writes the calibration value through a write port and can read it back. A new value is held until the window in progress completes, and the next window then uses it.

Top module: `rtcc_pulse_swallow`

## Requirements
- R1: While reset is asserted, and directly after it, `tick_out` is 0, the read-back value is 0, the window position is 0 and the active calibration value is 0.
- R2: A write with `cal_we` high stores `cal_wdata[6:0]` as the calibration value. From the next cycle `cal_rdata[6:0]` returns it, and without a write it holds.
- R3: Bits of `cal_rdata` above bit 6 always read 0, whatever was written to them.
- R4: `tick_out` is a registered copy of `tick_in`, one cycle later, minus the dropped pulses. It is never 1 without a `tick_in` in the cycle before. With an active calibration value of 0, every tick passes.
- R5: The window position advances by one only on a `tick_in` cycle and wraps to 0 after 2^WIN_BITS ticks. Idle cycles neither move it nor produce output.
- R6: Every complete window removes exactly as many ticks as the active calibration value.
- R7: A tick at window position p is removed if and only if bit_reverse(p), over WIN_BITS bits, is less than the active calibration value. A position whose low WIN_BITS-7 bits are not all zero is never removed.
- R8: The active calibration value is loaded from the register only on the tick that completes a window. A write in the middle of a window leaves the rest of that window under the old value. A write in the same cycle as the completing tick lands after that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_in | input | 1 | One-cycle enable, one per input clock pulse |
| cal_we | input | 1 | Calibration register write strobe |
| cal_wdata | input | REG_W (16) | Write data; bits 6:0 hold the calibration value |
| cal_rdata | output | REG_W (16) | Read-back; bits 6:0 calibration value, rest 0 |
| tick_out | output | 1 | Calibrated tick stream, one cycle behind `tick_in` |

## Verification
The assertions assume that `tick_in` is a plain per-cycle enable with at most one pulse per system clock, that WIN_BITS is larger than the 7-bit field, and that `rst_n` is driven without glitches. The bench builds the block with a 10-bit window, so that many whole windows fit in a short run. It drives ticks every cycle, every second cycle or every third cycle, and it places its writes at arbitrary window positions, including junk in the reserved bits. The expected stream comes from a bench-side window model of bit-reversed positions, and per-window drop counts are taken from the observed output.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
  localparam int CAL_W = 7;
  localparam int REG_W = 16;
  localparam int WIN_BITS = 20;
endpackage

// File: rtl/rtcc_rst_sync.sv
module rtcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rtcc_cal_reg.sv
module rtcc_cal_reg #(
  parameter int REG_W = 16,
  parameter int CAL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [CAL_W-1:0] cal_q
);
  localparam int PAD_W = REG_W - CAL_W;

  logic [CAL_W-1:0] cal_d;
  logic             unused_hi;

  assign unused_hi = ^wdata[REG_W-1:CAL_W];

  always_comb begin
    cal_d = cal_q;
    if (we) cal_d = wdata[CAL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= '0;
    else        cal_q <= cal_d;
  end

  assign rdata = {{PAD_W{1'b0}}, cal_q};

  // R2 R3
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == {{PAD_W{1'b0}}, $past(wdata[CAL_W-1:0])}));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/rtcc_window.sv
module rtcc_window #(
  parameter int WIN_BITS = 20,
  parameter int CAL_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                drop,
  input  logic [CAL_W-1:0]    cal_q,
  output logic [WIN_BITS-1:0] pos_q,
  output logic [CAL_W-1:0]    act_q,
  output logic                quota_ok
);
  localparam logic [WIN_BITS-1:0] LAST_POS = '1;

  logic [WIN_BITS-1:0] pos_d;
  logic [CAL_W-1:0]    act_d;
  logic [CAL_W-1:0]    used_q, used_d;
  logic                wrap;

  assign wrap     = tick && (pos_q == LAST_POS);
  assign quota_ok = (used_q < act_q);

  always_comb begin
    pos_d  = pos_q;
    act_d  = act_q;
    used_d = used_q;
    if (tick) pos_d = pos_q + 1'b1;
    if (wrap) begin
      act_d  = cal_q;
      used_d = '0;
    end else if (tick && drop) begin
      used_d = used_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      act_q  <= '0;
      used_q <= '0;
    end else begin
      pos_q  <= pos_d;
      act_q  <= act_d;
      used_q <= used_d;
    end
  end

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pos_q));
  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));
  // R6
  used_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= act_q);
endmodule

// File: rtl/rtcc_gate.sv
module rtcc_gate #(
  parameter int WIN_BITS = 20,
  parameter int CAL_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [WIN_BITS-1:0] pos,
  input  logic [CAL_W-1:0]    act,
  input  logic                quota_ok,
  output logic                drop,
  output logic                tick_out
);
  localparam int SPAN = WIN_BITS - CAL_W;

  logic [WIN_BITS-1:0] rev;
  logic                hit;
  logic                out_d;

  for (genvar i = 0; i < WIN_BITS; i++) begin : g_rev
    assign rev[i] = pos[WIN_BITS-1-i];
  end

  assign hit  = (rev < {{SPAN{1'b0}}, act});
  assign drop = tick && hit && quota_ok;

  always_comb begin
    out_d = 1'b0;
    if (tick) out_d = !drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_out <= 1'b0;
    else        tick_out <= out_d;
  end

  // R4
  out_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(tick));
  // R4
  zero_cal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act == '0) |=> tick_out);
  // R7
  spread_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pos[SPAN-1:0] != '0) |=> tick_out);
endmodule

// File: rtl/rtcc_pulse_swallow.sv
module rtcc_pulse_swallow #(
  parameter int WIN_BITS = rtcc_pkg::WIN_BITS,
  parameter int CAL_W    = rtcc_pkg::CAL_W,
  parameter int REG_W    = rtcc_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             cal_we,
  input  logic [REG_W-1:0] cal_wdata,
  output logic [REG_W-1:0] cal_rdata,
  output logic             tick_out
);
  logic                rst_n_s;
  logic [CAL_W-1:0]    cal_q;
  logic [WIN_BITS-1:0] pos_q;
  logic [CAL_W-1:0]    act_q;
  logic                quota_ok;
  logic                drop;

  rtcc_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  rtcc_cal_reg #(.REG_W(REG_W), .CAL_W(CAL_W)) u_reg (
    .clk  (clk),
    .rst_n(rst_n_s),
    .we   (cal_we),
    .wdata(cal_wdata),
    .rdata(cal_rdata),
    .cal_q(cal_q)
  );

  rtcc_window #(.WIN_BITS(WIN_BITS), .CAL_W(CAL_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick_in),
    .drop    (drop),
    .cal_q   (cal_q),
    .pos_q   (pos_q),
    .act_q   (act_q),
    .quota_ok(quota_ok)
  );

  rtcc_gate #(.WIN_BITS(WIN_BITS), .CAL_W(CAL_W)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick_in),
    .pos     (pos_q),
    .act     (act_q),
    .quota_ok(quota_ok),
    .drop    (drop),
    .tick_out(tick_out)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n_s |-> (!tick_out && cal_rdata == '0));
endmodule

// File: tb/tb_rtcc_pulse_swallow.sv
`timescale 1ns/1ps
module tb_rtcc_pulse_swallow;
  localparam int WIN = 10;
  localparam logic [WIN-1:0] MAXP = '1;
  localparam int NV = 6;
  // {gap[1:0], wdata[15:0]}
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 16'h0000}, {2'd0, 16'h0001}, {2'd1, 16'hFE05},
    {2'd2, 16'h0040}, {2'd0, 16'h007F}, {2'd1, 16'hAA33}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        cal_we = 1'b0;
  logic [15:0] cal_wdata = '0;
  logic [15:0] cal_rdata;
  logic        tick_out;

  int checks = 0, fails = 0, mism = 0, win_drops = 0, wraps = 0;
  logic [WIN-1:0] pos = '0;
  logic [6:0] act = '0, regm = '0;

  always #4 clk = ~clk;

  rtcc_pulse_swallow #(.WIN_BITS(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cal_we(cal_we),
    .cal_wdata(cal_wdata), .cal_rdata(cal_rdata), .tick_out(tick_out)
  );

  function automatic logic [WIN-1:0] bitrev(input logic [WIN-1:0] p);
    logic [WIN-1:0] r;
    for (int i = 0; i < WIN; i++) r[i] = p[WIN-1-i];
    return r;
  endfunction

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  // called at a negedge; result sampled at the following negedge
  task automatic step(input logic t, input logic we, input logic [15:0] wd);
    logic exp;
    tick_in = t; cal_we = we; cal_wdata = wd;
    @(posedge clk); @(negedge clk);
    exp = t && !(act != 0 && bitrev(pos) < {3'b0, act});  // R7
    if (tick_out !== exp) mism++;
    if (t && !tick_out) win_drops++;
    if (t) begin
      if (pos == MAXP) begin
        check("R6 drops per window", win_drops, act);
        win_drops = 0; act = regm; pos = '0; wraps++;  // R8 load on last tick
      end else pos++;
    end
    if (we) regm = wd[6:0];
    tick_in = 1'b0; cal_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 tick_out in reset", tick_out, 0);
    check("R1 rdata in reset", cal_rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pos = '0; act = '0; regm = '0; win_drops = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int c;
    @(negedge clk);
    do_reset();
    // R1 reset state passes ticks untouched (cal 0)
    mism = 0;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, '0);
    check("R1 R4 pass after reset mismatches", mism, 0);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0] gap;
      gap = VEC[v][17:16];
      mism = 0; wraps = 0; c = 0;
      step(1'b1, 1'b1, VEC[v][15:0]);  // mid-window write
      check("R3 reserved bits read 0", cal_rdata[15:7], 0);
      check("R2 cal readback", cal_rdata[6:0], VEC[v][6:0]);
      while (wraps < 2) begin
        c++;
        step((c % (gap + 1)) == 0, 1'b0, '0);
      end
      check("R7 R4 per-tick stream mismatches", mism, 0);
    end

    // R8: write in mid window under old value 0 -> rest of window drops nothing
    step(1'b1, 1'b1, 16'h0000);
    while (pos != 0) step(1'b1, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    while (pos != 10'd300) step(1'b1, 1'b0, '0);
    win_drops = 0;
    step(1'b1, 1'b1, 16'h007F);
    check("R2 readback 127", cal_rdata, 16'h007F);
    while (pos != MAXP) step(1'b1, 1'b0, '0);
    check("R8 old value kept to window end", win_drops, 0);
    mism = 0; wraps = 0;
    while (wraps < 2) step(1'b1, 1'b0, '0);  // R6 window of 127 checked at wrap
    check("R8 new value in next window mismatches", mism, 0);

    // R5: idle cycles produce nothing and do not move the window
    mism = 0;
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, '0);
    check("R5 idle output mismatches", mism, 0);
    wraps = 0;
    while (wraps < 1) step(1'b1, 1'b0, '0);
    check("R5 position after idle mismatches", mism, 0);

    // R8: write together with the completing tick lands after the load
    while (pos != MAXP) step(1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 16'h0003);
    check("R8 same-cycle write deferred act", act, 127);
    mism = 0; wraps = 0;
    while (wraps < 2) step(1'b1, 1'b0, '0);
    check("R8 R7 deferred write stream mismatches", mism, 0);

    // R1 mid-run reset clears everything
    do_reset();
    mism = 0;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0);
    check("R1 cal cleared after reset mismatches", mism, 0);
    check("R1 rdata after reset", cal_rdata, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule